// File: doc/BRIEF.md
# Two-Way Translation Cache

This block holds recently used virtual-to-physical page translations for a 32-bit effective address space with 4 KB pages. It has two independent arrays, one for instruction fetches and one for data accesses. Each array is organised as a set of two-way buckets indexed by the address bits just above the page offset. On a hit, a lookup returns the physical address. On a miss, the surrounding logic walks the page table and hands back the second word of the matching page table entry through the refill port.

The cached page table word also carries the page's changed flag. A store that hits a page whose changed flag is still clear reports a miss. The cached copy gets the flag set, and the table walker gets the chance to record the modification in memory. A second store to the same page then hits. The invalidate port clears one set in both arrays at once. Replacement inside a set follows a per-way most-recent flag.

Lookups are combinational. Every state update (recency, changed flag, refill, invalidate) takes effect on the rising clock edge.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry in both arrays is invalid, and no way is most-recent. Every lookup reports `lkHit`=0 with `lkPhys`=0.
- R2: A lookup hits when a valid way in the indexed set holds a tag equal to address bits 31:12. The set index is address bits 17:12. On a hit, `lkPhys` is the entry's frame (page table word bits 31:12) followed by address bits 11:0. On a miss, or when `lkValid`=0, `lkPhys` is 0. If both ways match, way 0 is used.
- R3: Access kind encoding is fetch=0, read=1, write=2, probe=3. Fetch lookups and fetch refills use the instruction array. All other kinds use the data array.
- R4: A write lookup that matches an entry whose changed flag (page table word bit 7) is 0 reports a miss. On that edge the flag is set in the cached word, so the same write repeated afterwards hits.
- R5: A non-probe hit makes the hit way most-recent and clears the most-recent flag of the other way in that set.
- R6: A probe lookup reports hits and misses like a read but changes no flag. A refill requested with the probe kind is ignored.
- R7: A refill replaces way 0 when way 0 is invalid or not most-recent, and way 1 otherwise. The filled way becomes valid and most-recent, with the refill address tag and the given page table word. The other way loses its most-recent flag.
- R8: An invalidate marks both ways of the set selected by its address bits 17:12 invalid, in both arrays.
- R9: When a refill and an invalidate hit the same set in the same cycle, the invalidate wins, and the set is left with both ways invalid.
- R10: When a lookup hit and a refill touch the same set in the same cycle, the refill chooses its way from the flags held before that edge. The refill's recency update overrides the lookup's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkKind | input | 2 | Lookup access kind (0 fetch, 1 read, 2 write, 3 probe) |
| lkAddr | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup produced a usable translation |
| lkPhys | output | 32 | Translated physical address, 0 on miss |
| rfValid | input | 1 | Refill request |
| rfKind | input | 2 | Access kind that caused the refill |
| rfAddr | input | 32 | Virtual address being refilled |
| rfPte | input | 32 | Second page table word (frame in 31:12, changed flag in bit 7) |
| invValid | input | 1 | Invalidate request |
| invAddr | input | 32 | Virtual address whose set is invalidated |

## Verification
The lookup port, the refill port and the invalidate port can all aim at the same set in one cycle. The sharpest case is a hit that reorders recency while a refill picks its victim in that very set. A refill racing an invalidate of its own set is a second such case. Directed steps force both collisions on chosen sets. Random traffic confined to four sets and four tags per set makes them happen often. Each outcome is judged by a bench model that takes the victim from the pre-edge flags and then applies recency, refill and invalidate in that order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_PROBE = 2'd3
  } acc_e;

  // position of the changed flag inside the cached page table word
  localparam int CHG_BIT = 7;

  // strobes from the control decode to the storage datapath
  typedef struct packed {
    logic lkArr;     // 1 = instruction array
    logic touchEn;
    logic touchWay;
    logic setChgEn;
    logic setChgWay;
    logic fillEn;
    logic fillArr;   // 1 = instruction array
    logic fillWay;
    logic invEn;
  } strobe_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic       lkValid,
  input  logic [1:0] lkKind,
  input  logic       rfValid,
  input  logic [1:0] rfKind,
  input  logic       invValid,
  input  logic [1:0] wayMatch,
  input  logic [1:0] wayChg,
  input  logic [1:0] rfSetMr,
  input  logic [1:0] rfSetInv,
  output strobe_t    strb,
  output logic       lkHit,
  output logic       hitWay
);

  logic anyMatch;
  logic needChg;

  always_comb begin
    anyMatch = |wayMatch;
    hitWay   = wayMatch[0] ? 1'b0 : 1'b1;
    needChg  = lkValid && (lkKind == ACC_WRITE) && anyMatch && !wayChg[hitWay];
    lkHit    = lkValid && anyMatch && !needChg;

    strb.lkArr     = (lkKind == ACC_FETCH);
    strb.touchEn   = lkHit && (lkKind != ACC_PROBE);
    strb.touchWay  = hitWay;
    strb.setChgEn  = needChg;
    strb.setChgWay = hitWay;
    strb.fillEn    = rfValid && (rfKind != ACC_PROBE);
    strb.fillArr   = (rfKind == ACC_FETCH);
    strb.fillWay   = (!rfSetMr[0] || rfSetInv[0]) ? 1'b0 : 1'b1;
    strb.invEn     = invValid;
  end

endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 64,
  localparam int IDX_W    = $clog2(SETS),
  localparam int VPN_W    = ADDR_W - PAGE_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [PAGE_BITS-1:0] lkOff,
  input  logic              lkHit,
  input  logic              hitWay,
  input  logic [VPN_W-1:0]  rfVpn,
  input  logic [ADDR_W-1:0] rfPte,
  input  logic [IDX_W-1:0]  invIdx,
  output logic [1:0]        wayMatch,
  output logic [1:0]        wayChg,
  output logic [1:0]        rfSetMr,
  output logic [1:0]        rfSetInv,
  output logic [ADDR_W-1:0] lkPhys
);

  logic [VPN_W-1:0]  tagQ [2][SETS][2];
  logic [ADDR_W-1:0] pteQ [2][SETS][2];
  logic              invQ [2][SETS][2];
  logic              mrQ  [2][SETS][2];

  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] rfIdx;

  assign lkIdx = lkVpn[IDX_W-1:0];
  assign rfIdx = rfVpn[IDX_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign wayMatch[w] = !invQ[strb.lkArr][lkIdx][w] &&
                         (tagQ[strb.lkArr][lkIdx][w] == lkVpn);
    assign wayChg[w]   = pteQ[strb.lkArr][lkIdx][w][CHG_BIT];
    assign rfSetMr[w]  = mrQ[strb.fillArr][rfIdx][w];
    assign rfSetInv[w] = invQ[strb.fillArr][rfIdx][w];
  end

  always_comb begin
    if (lkHit)
      lkPhys = {pteQ[strb.lkArr][lkIdx][hitWay][ADDR_W-1:PAGE_BITS], lkOff};
    else
      lkPhys = '0;
  end

  // update order on one edge: recency / changed flag, then refill, then invalidate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < 2; a++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < 2; w++) begin
            tagQ[a][s][w] <= '0;
            pteQ[a][s][w] <= '0;
            invQ[a][s][w] <= 1'b1;
            mrQ[a][s][w]  <= 1'b0;
          end
    end else begin
      if (strb.touchEn) begin
        mrQ[strb.lkArr][lkIdx][strb.touchWay]  <= 1'b1;
        mrQ[strb.lkArr][lkIdx][~strb.touchWay] <= 1'b0;
      end
      if (strb.setChgEn)
        pteQ[strb.lkArr][lkIdx][strb.setChgWay][CHG_BIT] <= 1'b1;
      if (strb.fillEn) begin
        tagQ[strb.fillArr][rfIdx][strb.fillWay]  <= rfVpn;
        pteQ[strb.fillArr][rfIdx][strb.fillWay]  <= rfPte;
        invQ[strb.fillArr][rfIdx][strb.fillWay]  <= 1'b0;
        mrQ[strb.fillArr][rfIdx][strb.fillWay]   <= 1'b1;
        mrQ[strb.fillArr][rfIdx][~strb.fillWay]  <= 1'b0;
      end
      if (strb.invEn)
        for (int a = 0; a < 2; a++)
          for (int w = 0; w < 2; w++)
            invQ[a][invIdx][w] <= 1'b1;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [1:0]        lkKind,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPhys,
  input  logic              rfValid,
  input  logic [1:0]        rfKind,
  input  logic [ADDR_W-1:0] rfAddr,
  input  logic [ADDR_W-1:0] rfPte,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr
);

  localparam int IDX_W = $clog2(SETS);

  strobe_t    strb;
  logic [1:0] wayMatch, wayChg, rfSetMr, rfSetInv;
  logic       hitWay;
  logic       unusedAddrBits;

  assign unusedAddrBits = ^{rfAddr[PAGE_BITS-1:0], invAddr[PAGE_BITS-1:0],
                            invAddr[ADDR_W-1:PAGE_BITS+IDX_W]};

  xlat_ctrl ctrl_i (
    .lkValid (lkValid),
    .lkKind  (lkKind),
    .rfValid (rfValid),
    .rfKind  (rfKind),
    .invValid(invValid),
    .wayMatch(wayMatch),
    .wayChg  (wayChg),
    .rfSetMr (rfSetMr),
    .rfSetInv(rfSetInv),
    .strb    (strb),
    .lkHit   (lkHit),
    .hitWay  (hitWay)
  );

  xlat_store #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .SETS     (SETS)
  ) store_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .lkVpn   (lkAddr[ADDR_W-1:PAGE_BITS]),
    .lkOff   (lkAddr[PAGE_BITS-1:0]),
    .lkHit   (lkHit),
    .hitWay  (hitWay),
    .rfVpn   (rfAddr[ADDR_W-1:PAGE_BITS]),
    .rfPte   (rfPte),
    .invIdx  (invAddr[PAGE_BITS+IDX_W-1:PAGE_BITS]),
    .wayMatch(wayMatch),
    .wayChg  (wayChg),
    .rfSetMr (rfSetMr),
    .rfSetInv(rfSetInv),
    .lkPhys  (lkPhys)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 64,
  localparam int IDX_W    = $clog2(SETS)
)(
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic [1:0]        lkKind,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic [ADDR_W-1:0] lkPhys,
  input logic              rfValid,
  input logic [1:0]        rfKind,
  input logic [ADDR_W-1:0] rfAddr,
  input logic              invValid,
  input logic [IDX_W-1:0]  invIdx
);

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkValid); // R2

  AST_MISS_ZERO_PHYS: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPhys == '0)); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkPhys[PAGE_BITS-1:0] == lkAddr[PAGE_BITS-1:0])); // R2

  AST_INV_SET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> !(lkHit &&
      lkAddr[PAGE_BITS+IDX_W-1:PAGE_BITS] == $past(invIdx))); // R8

  AST_INV_BEATS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && rfValid && rfAddr[PAGE_BITS+IDX_W-1:PAGE_BITS] == invIdx)
      |=> !(lkHit && lkAddr[ADDR_W-1:PAGE_BITS] == $past(rfAddr[ADDR_W-1:PAGE_BITS]))); // R9

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rfValid) && ($past(rfKind) == ACC_READ || $past(rfKind) == ACC_WRITE) &&
     !$past(invValid) && lkValid && lkKind == ACC_READ &&
     lkAddr[ADDR_W-1:PAGE_BITS] == $past(rfAddr[ADDR_W-1:PAGE_BITS]))
      |-> lkHit); // R7

endmodule

bind xlat_cache xlat_cache_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS),
  .SETS     (SETS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .lkValid (lkValid),
  .lkKind  (lkKind),
  .lkAddr  (lkAddr),
  .lkHit   (lkHit),
  .lkPhys  (lkPhys),
  .rfValid (rfValid),
  .rfKind  (rfKind),
  .rfAddr  (rfAddr),
  .invValid(invValid),
  .invIdx  (invAddr[PAGE_BITS+$clog2(SETS)-1:PAGE_BITS])
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSETS      = 64;
  localparam int RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [1:0]  lkKind = 2'd0;
  logic [31:0] lkAddr = '0;
  logic        lkHit;
  logic [31:0] lkPhys;
  logic        rfValid = 1'b0;
  logic [1:0]  rfKind = 2'd0;
  logic [31:0] rfAddr = '0;
  logic [31:0] rfPte = '0;
  logic        invValid = 1'b0;
  logic [31:0] invAddr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [19:0] mTag [2][NSETS][2];
  logic [31:0] mPte [2][NSETS][2];
  bit          mInv [2][NSETS][2];
  bit          mMr  [2][NSETS][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkKind(lkKind), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkPhys(lkPhys),
    .rfValid(rfValid), .rfKind(rfKind), .rfAddr(rfAddr), .rfPte(rfPte),
    .invValid(invValid), .invAddr(invAddr)
  );

  function automatic int arrOf(logic [1:0] k);
    return (k == 2'd0) ? 1 : 0;
  endfunction

  task automatic modelReset();
    for (int a = 0; a < 2; a++)
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < 2; w++) begin
          mTag[a][s][w] = '0; mPte[a][s][w] = '0;
          mInv[a][s][w] = 1'b1; mMr[a][s][w] = 1'b0;
        end
  endtask

  task automatic modelLookup(output bit hit, output logic [31:0] phys,
                             output bit needChg, output int way);
    int a = arrOf(lkKind);
    int s = int'(lkAddr[17:12]);
    bit m0 = !mInv[a][s][0] && mTag[a][s][0] == lkAddr[31:12];
    bit m1 = !mInv[a][s][1] && mTag[a][s][1] == lkAddr[31:12];
    way = m0 ? 0 : 1;
    needChg = lkValid && lkKind == 2'd2 && (m0 || m1) && !mPte[a][s][way][7];
    hit = lkValid && (m0 || m1) && !needChg;
    phys = hit ? {mPte[a][s][way][31:12], lkAddr[11:0]} : 32'h0;
  endtask

  task automatic modelCommit();
    bit hit, needChg;
    logic [31:0] phys;
    int way;
    int la = arrOf(lkKind);
    int ls = int'(lkAddr[17:12]);
    int fa = arrOf(rfKind);
    int fs = int'(rfAddr[17:12]);
    int fw = (!mMr[fa][fs][0] || mInv[fa][fs][0]) ? 0 : 1;
    modelLookup(hit, phys, needChg, way);
    if (hit && lkKind != 2'd3) begin
      mMr[la][ls][way] = 1'b1; mMr[la][ls][1-way] = 1'b0;
    end
    if (needChg) mPte[la][ls][way][7] = 1'b1;
    if (rfValid && rfKind != 2'd3) begin
      mTag[fa][fs][fw] = rfAddr[31:12]; mPte[fa][fs][fw] = rfPte;
      mInv[fa][fs][fw] = 1'b0; mMr[fa][fs][fw] = 1'b1; mMr[fa][fs][1-fw] = 1'b0;
    end
    if (invValid)
      for (int a = 0; a < 2; a++)
        for (int w = 0; w < 2; w++) mInv[a][int'(invAddr[17:12])][w] = 1'b1;
  endtask

  // inputs already driven after a falling edge; check, then cross the rising edge
  task automatic checkAndClock(string req);
    bit hit, needChg;
    logic [31:0] phys;
    int way;
    #1;
    modelLookup(hit, phys, needChg, way);
    checks++;
    if (lkHit !== hit || lkPhys !== phys) begin
      errors++;
      $display("FAIL %s: addr=%h kind=%0d got hit=%b phys=%h expected hit=%b phys=%h",
               req, lkAddr, lkKind, lkHit, lkPhys, hit, phys);
    end
    @(posedge clk);
    modelCommit();
    @(negedge clk);
  endtask

  task automatic step(bit lv, logic [1:0] lk, logic [31:0] la,
                      bit rv, logic [1:0] rk, logic [31:0] ra, logic [31:0] rp,
                      bit iv, logic [31:0] ia, string req);
    lkValid = lv; lkKind = lk; lkAddr = la;
    rfValid = rv; rfKind = rk; rfAddr = ra; rfPte = rp;
    invValid = iv; invAddr = ia;
    checkAndClock(req);
  endtask

  task automatic look(logic [1:0] k, logic [31:0] a, string req);
    step(1'b1, k, a, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic fill(logic [1:0] k, logic [31:0] a, logic [31:0] p, string req);
    step(1'b0, 2'd1, 32'h0, 1'b1, k, a, p, 1'b0, 32'h0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: nothing hits after reset
    look(2'd1, 32'h0000_0123, "R1");
    look(2'd0, 32'h8000_0abc, "R1");

    // R2 / R3: data fill seen by read, not by fetch
    fill(2'd1, 32'h1234_5000, 32'hABCD_E080, "R2");
    look(2'd1, 32'h1234_5678, "R2");
    look(2'd0, 32'h1234_5678, "R3");
    fill(2'd0, 32'h2000_1000, 32'h0055_5080, "R3");
    look(2'd1, 32'h2000_1004, "R3");
    look(2'd0, 32'h2000_1004, "R3");

    // R4: changed flag clear -> write misses once, then hits
    fill(2'd2, 32'h3000_2000, 32'h0777_7000, "R4");
    look(2'd2, 32'h3000_2010, "R4");
    look(2'd2, 32'h3000_2010, "R4");
    look(2'd1, 32'h3000_2010, "R4");

    // R5 / R7: recency drives the victim choice
    fill(2'd1, 32'h0000_3000, 32'h0001_1080, "R7");
    fill(2'd1, 32'h0100_3000, 32'h0002_2080, "R7");
    look(2'd1, 32'h0000_3000, "R5");
    fill(2'd1, 32'h0200_3000, 32'h0003_3080, "R7");
    look(2'd1, 32'h0000_3000, "R5");
    look(2'd1, 32'h0100_3000, "R7");
    look(2'd1, 32'h0200_3000, "R7");

    // R6: probe changes no flag, probe refill ignored
    fill(2'd1, 32'h0000_4000, 32'h0004_4080, "R6");
    fill(2'd1, 32'h0100_4000, 32'h0005_5080, "R6");
    look(2'd3, 32'h0000_4000, "R6");
    fill(2'd1, 32'h0200_4000, 32'h0006_6080, "R6");
    look(2'd3, 32'h0000_4000, "R6");
    look(2'd3, 32'h0100_4000, "R6");
    fill(2'd3, 32'h0300_5000, 32'h0007_7080, "R6");
    look(2'd1, 32'h0300_5000, "R6");

    // R8: invalidate by set, both arrays
    fill(2'd1, 32'h0400_6000, 32'h0008_8080, "R8");
    fill(2'd0, 32'h0400_6000, 32'h0009_9080, "R8");
    step(1'b0, 2'd1, 32'h0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b1, 32'h0F00_6ABC, "R8");
    look(2'd1, 32'h0400_6000, "R8");
    look(2'd0, 32'h0400_6000, "R8");

    // R9: refill and invalidate of the same set in one cycle
    step(1'b0, 2'd1, 32'h0, 1'b1, 2'd1, 32'h0500_7000, 32'h000A_A080,
         1'b1, 32'h0000_7000, "R9");
    look(2'd1, 32'h0500_7000, "R9");

    // R10: lookup hit and refill of the same set in one cycle
    fill(2'd1, 32'h0000_8000, 32'h000B_B080, "R10");
    fill(2'd1, 32'h0100_8000, 32'h000C_C080, "R10");
    step(1'b1, 2'd1, 32'h0000_8000, 1'b1, 2'd1, 32'h0200_8000, 32'h000D_D080,
         1'b0, 32'h0, "R10");
    look(2'd1, 32'h0000_8000, "R10");
    look(2'd1, 32'h0100_8000, "R10");
    look(2'd1, 32'h0200_8000, "R10");

    // random traffic on four sets, four tags per set
    for (int i = 0; i < RAND_STEPS; i++) begin
      logic [31:0] la = {12'h0, 2'($urandom), 4'h0, 2'($urandom), 12'($urandom)};
      logic [31:0] ra = {12'h0, 2'($urandom), 4'h0, 2'($urandom), 12'h0};
      logic [31:0] ia = {12'h0, 2'($urandom), 4'h0, 2'($urandom), 12'h0};
      logic [31:0] rp = {20'($urandom), 4'h0, 1'($urandom), 7'h0};
      step(($urandom % 4) != 0, 2'($urandom), la,
           ($urandom % 3) == 0, 2'($urandom), ra, rp,
           ($urandom % 16) == 0, ia, "R2 R4 R5 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule